// File: doc/BRIEF.md
# Idle and Power-Down Sequencer

This block runs the low-power modes of a small microcontroller core. Software writes a four-bit mode field that holds an idle request, a power-down request and two general-purpose flag bits. The block then gates the CPU clock, the peripheral clock and the oscillator. It also holds the external bus strobes and port pins, and it clears the mode bits in hardware when the core wakes.

Idle stops only the CPU clock. Timers, serial logic and interrupt logic keep running. Any enabled interrupt, delivered on `irq_req` by the priority logic, ends idle. Power-down stops the oscillator. Only the two external interrupt pins, each with its own enable, can end it, and a qualified hardware reset can also end it. The wake from power-down has three steps:

1. An enabled pin held low restarts the oscillator.
2. A stabilisation counter must expire.
3. The exit completes only once the pin that started the wake, or another armed pin, is released high.

The pin that was released first is reported, so that the interrupt logic can serve the right source. The oscillator is modelled as an enable output. The block itself keeps running on `clk`.

The external reset pin takes effect only after it has been held for a parameterised number of cycles. It then returns the block to run mode and clears every mode bit.

Top module: `lpm_seq`

## Requirements
- R1: After `rst_n` reset: `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1; `bus_hold`, `rst_out`, `idle_clr`, `pd_clr`, `wake_src` and `mode_rd` are 0.
- R2: In run mode, a write with `wr_data[0]`=1 and `wr_data[1]`=0 enters idle on the next cycle. In idle, `cpu_clk_en`=0, `periph_clk_en`=1, `osc_en`=1, `bus_hold`=1 and `mode_rd[0]`=1.
- R3: In idle, `irq_req`=1 returns the block to run on the next cycle. In that cycle `mode_rd[0]`=0, `cpu_clk_en`=1, and `idle_clr` is 1 for exactly that one cycle.
- R4: In run mode, a write with `wr_data[1]`=1 enters power-down. This holds even when `wr_data[0]`=1 as well, in which case `mode_rd[0]` stays 0. In power-down, `mode_rd[1]`=1, and `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R5: While the oscillator is stopped, neither `irq_req` nor a low level on a pin whose `xint_en` bit is 0 has any effect. `osc_en` and `mode_rd` stay unchanged.
- R6: Pin i (`xint_n[i]`, active low) restarts the oscillator when `xint_en[i]`=1 and the pin is low. The restart happens after `SYNC_STAGES` synchroniser cycles. `cpu_clk_en` stays 0 for as long as the pin is held low.
- R7: The power-down exit completes on the cycle after the stabilisation counter has expired and an armed pin reads high. The exit clears `mode_rd[1]`, sets `cpu_clk_en` and pulses `pd_clr` once. If the pin is released early, the block spends exactly `WARM_CYCLES` cycles with `osc_en`=1 and `cpu_clk_en`=0.
- R8: `wake_src` is one-hot. Bit i marks pin i as the first armed pin released during the wake. If both pins are released in the same cycle, pin 0 is reported.
- R9: Flag bits `wr_data[3:2]` are stored in `mode_rd[3:2]`. They change only on a write in run mode or a reset, and never because of a mode transition.
- R10: Writes made while the block is not in run mode are ignored.
- R11: A reset is applied once `ext_rst` has been high for `RST_HOLD` consecutive cycles. `rst_out` is then 1, and on the next cycle the block is back in run mode with `mode_rd`=0. A shorter high pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | External reset pin, qualified by hold time |
| wr_en | input | 1 | Software write strobe for the mode field |
| wr_data | input | 4 | Write data: [0] idle, [1] power-down, [3:2] flags |
| irq_req | input | 1 | Any enabled interrupt pending, from priority logic |
| xint_n | input | 2 | External interrupt pins, active low, asynchronous |
| xint_en | input | 2 | Per-pin interrupt enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Timer, serial and interrupt clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| bus_hold | output | 1 | Hold strobes high and ports at their last values |
| rst_out | output | 1 | Qualified reset to the core |
| mode_rd | output | 4 | Readback: [0] idle, [1] power-down, [3:2] flags |
| idle_clr | output | 1 | One-cycle pulse when hardware clears the idle bit |
| pd_clr | output | 1 | One-cycle pulse when hardware clears the power-down bit |
| wake_src | output | 2 | One-hot pin that completed the last power-down exit |

## Verification
The bench sweeps every combination of pin enables against the choice of pin pulled low. A design that ignored the enable, or woke on the wrong pin, would start the oscillator when it should not, or report the wrong source.

It measures the warm-up window in cycles for two cases: an early release and a long hold. A design that let release bypass the counter would shorten the window below `WARM_CYCLES`. A design that woke on the falling edge would let the CPU clock run while the pin was still low.

It releases the two pins in a staggered order and then together. A design that re-evaluated priority at expiry would name pin 0 when pin 1 was in fact released first.

It holds the reset pin one cycle short of the limit and then exactly to the limit. An off-by-one qualifier would either reset early or fail to reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int N_XINT = 2;
  localparam int MODE_W = 4;

  // Bit positions in the software mode field
  localparam int B_IDLE = 0;
  localparam int B_PD   = 1;
  localparam int B_GF0  = 2;
  localparam int B_GF1  = 3;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_IDLE    = 2'd1,
    ST_PD_OFF  = 2'd2,
    ST_PD_WAKE = 2'd3
  } lpm_state_e;

  // One-hot of the lowest set bit; ties go to pin 0
  function automatic logic [N_XINT-1:0] pick_first(input logic [N_XINT-1:0] v);
    logic [N_XINT-1:0] r;
    r = '0;
    for (int i = N_XINT - 1; i >= 0; i--) begin
      if (v[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  // Next state of a saturating up-counter
  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Mode selected by a software write; power-down has precedence
  function automatic lpm_state_e write_target(input logic [MODE_W-1:0] d);
    if (d[B_PD])        return ST_PD_OFF;
    else if (d[B_IDLE]) return ST_IDLE;
    else                return ST_RUN;
  endfunction

endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;   // pins idle high
      else if (STAGES == 1) chain_q <= din[b];
      else chain_q <= {chain_q[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual
  import lpm_pkg::*;
#(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  output logic hw_rst
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!ext_rst) cnt_q <= '0;
    else               cnt_q <= CW'(sat_inc(int'(cnt_q), HOLD));
  end

  assign hw_rst = (cnt_q == HOLD_V);

endmodule

// File: rtl/lpm_warm_timer.sv
module lpm_warm_timer
  import lpm_pkg::*;
#(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else              cnt_q <= CW'(sat_inc(int'(cnt_q), LEN - 1));
  end

  assign done = active && (cnt_q == LAST);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int WARM_CYCLES = 8,
  parameter int RST_HOLD    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  input  logic       irq_req,
  input  logic [1:0] xint_n,
  input  logic [1:0] xint_en,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       bus_hold,
  output logic       rst_out,
  output logic [3:0] mode_rd,
  output logic       idle_clr,
  output logic       pd_clr,
  output logic [1:0] wake_src
);

  lpm_state_e        state_q, state_d;
  logic [N_XINT-1:0] xint_s;
  logic [N_XINT-1:0] pin_low, rel_now, rel_first;
  logic [N_XINT-1:0] armed_q, rel_q, wake_src_q;
  logic [1:0]        gf_q;
  logic              hw_rst, sw_wr, warm_active, warm_done;
  logic              pin_wake, wake_exit, irq_exit;
  logic              idle_clr_q, pd_clr_q;

  lpm_pin_sync #(.W(N_XINT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(xint_n), .dout(xint_s)
  );

  lpm_rst_qual #(.HOLD(RST_HOLD)) u_rstq (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .hw_rst(hw_rst)
  );

  assign warm_active = (state_q == ST_PD_WAKE);

  lpm_warm_timer #(.LEN(WARM_CYCLES)) u_warm (
    .clk(clk), .rst_n(rst_n), .active(warm_active), .done(warm_done)
  );

  // Named events
  assign pin_low   = xint_en & ~xint_s;
  assign rel_now   = armed_q & xint_en & xint_s;
  assign rel_first = (rel_q != '0) ? rel_q : pick_first(rel_now);
  assign sw_wr     = wr_en && (state_q == ST_RUN) && !hw_rst;
  assign pin_wake  = (state_q == ST_PD_OFF) && (pin_low != '0);
  assign wake_exit = warm_done && (rel_first != '0);
  assign irq_exit  = (state_q == ST_IDLE) && irq_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (sw_wr) state_d = write_target(wr_data);
      ST_IDLE:    if (irq_req) state_d = ST_RUN;
      ST_PD_OFF:  if (pin_wake) state_d = ST_PD_WAKE;
      ST_PD_WAKE: if (wake_exit) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
    if (hw_rst) state_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      armed_q    <= '0;
      rel_q      <= '0;
      wake_src_q <= '0;
      gf_q       <= '0;
      idle_clr_q <= 1'b0;
      pd_clr_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      idle_clr_q <= irq_exit && !hw_rst;
      pd_clr_q   <= wake_exit && !hw_rst;

      if (hw_rst) begin
        gf_q       <= '0;
        armed_q    <= '0;
        rel_q      <= '0;
        wake_src_q <= '0;
      end else begin
        if (sw_wr) gf_q <= {wr_data[B_GF1], wr_data[B_GF0]};

        if (sw_wr && (write_target(wr_data) == ST_PD_OFF)) begin
          armed_q    <= '0;
          rel_q      <= '0;
          wake_src_q <= '0;
        end else if (pin_wake) begin
          armed_q <= pin_low;
        end else if (warm_active) begin
          armed_q <= armed_q | pin_low;
          if (rel_q == '0) rel_q <= pick_first(rel_now);
          if (wake_exit) wake_src_q <= rel_first;
        end
      end
    end
  end

  assign cpu_clk_en    = (state_q == ST_RUN);
  assign periph_clk_en = (state_q == ST_RUN) || (state_q == ST_IDLE);
  assign osc_en        = (state_q != ST_PD_OFF);
  assign bus_hold      = (state_q != ST_RUN);
  assign rst_out       = hw_rst;
  assign mode_rd       = {gf_q, warm_active || (state_q == ST_PD_OFF), state_q == ST_IDLE};
  assign idle_clr      = idle_clr_q;
  assign pd_clr        = pd_clr_q;
  assign wake_src      = wake_src_q;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_rst,
  input logic       irq_req,
  input logic       sw_wr,
  input logic       pin_wake,
  input logic       warm_done,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic [3:0] mode_rd,
  input logic [1:0] wake_src,
  input logic       pd_clr
);

  // R2
  idle_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd[0] |-> !cpu_clk_en && periph_clk_en && osc_en);

  // R4
  pd_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd[1] && !osc_en) |-> !cpu_clk_en && !periph_clk_en);

  // R3
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd[0] && irq_req) |=> !mode_rd[0] && cpu_clk_en);

  // R5
  pd_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd[1] && !osc_en && !pin_wake && !hw_rst) |=> !osc_en);

  // R7
  warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(mode_rd[1]) && !$past(hw_rst)) |-> $past(warm_done));

  // R7
  pd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_clr |-> cpu_clk_en && !mode_rd[1]);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_rst && !sw_wr) |=> $stable(mode_rd[3:2]));

  // R8
  wake_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_src));

  // R11
  hw_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> cpu_clk_en && (mode_rd == 4'b0000));

endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .irq_req(irq_req),
  .sw_wr(sw_wr), .pin_wake(pin_wake), .warm_done(warm_done),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
  .mode_rd(mode_rd), .wake_src(wake_src), .pd_clr(pd_clr)
);

// File: tb/lpm_seq_test.sv
`timescale 1ns/1ps
module lpm_seq_test;

  localparam int WARM = 8;
  localparam int RHOLD = 24;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n, ext_rst, wr_en, irq_req;
  logic [3:0] wr_data;
  logic [1:0] xint_n, xint_en;
  logic       cpu_clk_en, periph_clk_en, osc_en, bus_hold, rst_out, idle_clr, pd_clr;
  logic [3:0] mode_rd;
  logic [1:0] wake_src;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lpm_seq #(.WARM_CYCLES(WARM), .RST_HOLD(RHOLD), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_req(irq_req), .xint_n(xint_n), .xint_en(xint_en),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .bus_hold(bus_hold), .rst_out(rst_out), .mode_rd(mode_rd),
    .idle_clr(idle_clr), .pd_clr(pd_clr), .wake_src(wake_src)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [3:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = 4'b0;
  endtask

  // Wait (bounded) for osc_en, returns 1 if seen
  task automatic wait_osc(output bit seen);
    seen = 0;
    for (int i = 0; i < SYNC + 6; i++) begin
      if (osc_en) begin seen = 1; break; end
      cyc(1);
    end
  endtask

  // Wake from power-down through pin 0, leaving the block in run mode
  task automatic wake_pin0;
    bit s;
    xint_en = 2'b01; xint_n = 2'b10;
    wait_osc(s);
    xint_n = 2'b11;
    for (int i = 0; i < WARM + 10 && !cpu_clk_en; i++) cyc(1);
  endtask

  initial begin
    bit seen;
    int n;
    bit rose_early;
    rst_n = 0; ext_rst = 0; wr_en = 0; wr_data = 0; irq_req = 0;
    xint_n = 2'b11; xint_en = 2'b00;
    cyc(3);
    rst_n = 1;
    cyc(1);

    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 periph_clk_en", periph_clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 bus_hold", bus_hold, 0);
    chk("R1 mode_rd", mode_rd, 0);
    chk("R1 wake_src", wake_src, 0);
    chk("R1 rst_out", rst_out, 0);

    // R9 flag storage sweep
    for (int v = 0; v < 4; v++) begin
      sw_write(4'(v << 2));
      chk("R9 flags written", mode_rd, v << 2);
      chk("R9 stay run", cpu_clk_en, 1);
    end

    // R2 idle entry with flags 10
    sw_write(4'b1001);
    chk("R2 cpu off", cpu_clk_en, 0);
    chk("R2 periph on", periph_clk_en, 1);
    chk("R2 osc on", osc_en, 1);
    chk("R2 bus_hold", bus_hold, 1);
    chk("R2 mode_rd", mode_rd, 4'b1001);

    // R10 write ignored in idle
    sw_write(4'b0110);
    chk("R10 idle write ignored", mode_rd, 4'b1001);

    // R3 idle exit by interrupt
    cyc(3);
    chk("R3 idle holds without irq", mode_rd, 4'b1001);
    irq_req = 1;
    cyc(1);
    irq_req = 0;
    chk("R3 idle bit cleared", mode_rd, 4'b1000);
    chk("R3 cpu back on", cpu_clk_en, 1);
    chk("R3 idle_clr pulse", idle_clr, 1);
    cyc(1);
    chk("R3 idle_clr single", idle_clr, 0);
    chk("R9 flags kept over idle", mode_rd[3:2], 2'b10);

    // R4 both bits: power-down wins
    sw_write(4'b0011);
    chk("R4 mode_rd", mode_rd, 4'b0010);
    chk("R4 osc off", osc_en, 0);
    chk("R4 periph off", periph_clk_en, 0);
    chk("R4 cpu off", cpu_clk_en, 0);

    // R5 irq and disabled pins ignored; R10 write ignored
    irq_req = 1; xint_en = 2'b00; xint_n = 2'b00;
    cyc(SYNC + 4);
    chk("R5 osc stays off", osc_en, 0);
    chk("R5 mode_rd", mode_rd, 4'b0010);
    irq_req = 0; xint_n = 2'b11;
    sw_write(4'b1100);
    chk("R10 pd write ignored", mode_rd, 4'b0010);
    wake_pin0;
    chk("R7 back to run", cpu_clk_en, 1);

    // R6 sweep: enable pattern x pin choice
    for (int en = 0; en < 4; en++) begin
      for (int sel = 0; sel < 2; sel++) begin
        int exp_w;
        exp_w = (en >> sel) & 1;
        sw_write(4'b0010);
        xint_en = 2'(en);
        xint_n = ~(2'b01 << sel);
        cyc(SYNC + 3);
        chk($sformatf("R6 en=%0d pin=%0d osc", en, sel), osc_en, exp_w);
        chk($sformatf("R6 en=%0d pin=%0d cpu held", en, sel), cpu_clk_en, 0);
        xint_n = 2'b11;
        cyc(WARM + SYNC + 3);
        chk($sformatf("R7 en=%0d pin=%0d exit", en, sel), cpu_clk_en, exp_w);
        if (exp_w == 1)
          chk($sformatf("R8 en=%0d pin=%0d src", en, sel), wake_src, 1 << sel);
        else
          wake_pin0;
      end
    end

    // R7 early release: exact warm window
    sw_write(4'b0010);
    xint_en = 2'b01; xint_n = 2'b10;
    wait_osc(seen);
    chk("R6 restart seen", seen, 1);
    xint_n = 2'b11;
    n = 0;
    while (!cpu_clk_en && n < WARM + 20) begin n++; cyc(1); end
    chk("R7 warm window", n, WARM);
    chk("R7 pd_clr pulse", pd_clr, 1);
    chk("R7 pd bit cleared", mode_rd[1], 0);

    // R6/R7 long hold: no exit while pin low
    sw_write(4'b0010);
    xint_n = 2'b10;
    wait_osc(seen);
    rose_early = 0;
    for (int i = 0; i < 20; i++) begin
      if (cpu_clk_en) rose_early = 1;
      cyc(1);
    end
    chk("R6 cpu off while pin low", rose_early, 0);
    xint_n = 2'b11;
    n = 0;
    while (!cpu_clk_en && n < 20) begin n++; cyc(1); end
    chk("R7 exit after release", cpu_clk_en, 1);
    chk("R7 exit latency after release", (n >= 1 && n <= SYNC + 1), 1);

    // R8 staggered release: pin 1 first
    sw_write(4'b0010);
    xint_en = 2'b11; xint_n = 2'b00;
    wait_osc(seen);
    xint_n = 2'b10;
    cyc(3);
    xint_n = 2'b11;
    cyc(WARM + 4);
    chk("R8 first released pin1", wake_src, 2'b10);

    // R8 simultaneous release: pin 0
    sw_write(4'b0010);
    xint_n = 2'b00;
    wait_osc(seen);
    xint_n = 2'b11;
    cyc(WARM + 4);
    chk("R8 tie goes to pin0", wake_src, 2'b01);

    // R11 short reset pulse ignored (in idle)
    sw_write(4'b0001);
    ext_rst = 1;
    cyc(RHOLD - 1);
    chk("R11 no rst_out early", rst_out, 0);
    ext_rst = 0;
    cyc(2);
    chk("R11 short pulse ignored", mode_rd, 4'b0001);

    // R11 full reset from power-down with flags set
    irq_req = 1; cyc(1); irq_req = 0;
    sw_write(4'b1110);
    chk("R11 pd with flags", mode_rd, 4'b1110);
    ext_rst = 1;
    cyc(RHOLD);
    chk("R11 rst_out", rst_out, 1);
    ext_rst = 0;
    cyc(1);
    chk("R11 mode cleared", mode_rd, 0);
    chk("R11 cpu on", cpu_clk_en, 1);
    chk("R11 osc on", osc_en, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule